// File: doc/BRIEF.md
# Strided Row Request Expander

This block sits between a job source and a one-dimensional data mover. It takes in a two-dimensional copy job and turns it into a series of flat row requests. A job carries a source base, a destination base, a row length in bytes, separate source and destination strides, a repetition count and a set of pass-along option flags. Both the job side and the row side use a valid/ready handshake.

Row k of a job reads from source base plus k times the source stride and writes to destination base plus k times the destination stride. Every row has the same byte length and the same flags. A repetition count of zero means one row, equal to the base transfer. A build parameter can strip the two-dimensional feature, so that every job becomes exactly one row. The mover reports each finished row with a one-cycle completion pulse. When the number of completions equals the number of rows in the job, the block raises a one-cycle job-done pulse and then becomes free for the next job.

Top module: `dmx_row_expander`

## Requirements
- R1: Out of reset `job_ready_o` is 1, `row_valid_o` is 0 and `job_done_o` is 0.
- R2: A job is taken on a clock edge where `job_valid_i` and `job_ready_o` are both 1. The first row request is valid in the cycle after that edge and carries the job's source base, destination base, length and flags.
- R3: With `ENABLE_2D`=1 and a repetition count N greater than 0, exactly N rows are emitted. Row k (k = 0..N-1) has source `src + k*src_stride` and destination `dst + k*dst_stride`.
- R4: With `ENABLE_2D`=1 and a repetition count of 0, exactly one row is emitted, and it equals the base transfer.
- R5: Every row of a job carries the job's byte length and flags unchanged.
- R6: While `row_valid_o` is 1 and `row_ready_i` is 0, `row_valid_o` stays 1 in the next cycle and every row field holds its value.
- R7: `job_ready_o` is 0 from the edge that takes a job until the job-done pulse. Job offers made in that window are ignored.
- R8: `job_done_o` is a one-cycle pulse. It appears in the cycle after the edge at which `row_done_i` brings the completion count up to the job's row count. A `row_done_i` that arrives while no job is tracked is ignored.
- R9: With `ENABLE_2D`=0, every job produces exactly one row at its base addresses, whatever its repetition count.
- R10: Address arithmetic wraps modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| job_valid_i | input | 1 | Job offer |
| job_ready_o | output | 1 | Block can take a job |
| job_src_i | input | ADDR_W | Source base address |
| job_dst_i | input | ADDR_W | Destination base address |
| job_len_i | input | LEN_W | Bytes per row |
| job_src_stride_i | input | ADDR_W | Source step between rows |
| job_dst_stride_i | input | ADDR_W | Destination step between rows |
| job_reps_i | input | REPS_W | Repetition count (0 means a single row) |
| job_flags_i | input | FLAG_W | Options copied into each row |
| row_valid_o | output | 1 | Row request valid |
| row_ready_i | input | 1 | Mover takes the row |
| row_src_o | output | ADDR_W | Row source address |
| row_dst_o | output | ADDR_W | Row destination address |
| row_len_o | output | LEN_W | Row length in bytes |
| row_flags_o | output | FLAG_W | Row options |
| row_done_i | input | 1 | Mover has finished one row |
| job_done_o | output | 1 | All rows of the job are complete |

## Verification
The embedded properties check the following on every cycle:
- a stalled row request is held,
- the job side stays closed while rows are pending,
- each address register advances by exactly its stride on a handshake,
- the length and flags do not change inside a job,
- the completion counter never reaches the row total while a job is still tracked,
- the done signal never lasts longer than one cycle.

Several behaviours can only be shown by the bench scenarios:
- the exact row count for each repetition value, including zero,
- the arithmetic address sequence across the wrap boundary,
- the cycle in which done appears,
- that stray completions are ignored,
- the single-row behaviour of the flat build.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    // Emission state of the row sequencer
    typedef enum logic [0:0] {
        GEN_IDLE = 1'b0,
        GEN_EMIT = 1'b1
    } gen_state_e;

    // Number of address channels that advance per row (source, destination)
    localparam int unsigned NUM_ADDR_CH = 2;

endpackage

// File: rtl/dmx_addr_walker.sv
module dmx_addr_walker #(
    parameter int unsigned AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] stride_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] stride;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        if (load_i) begin
            walk_d.addr   = base_i;
            walk_d.stride = stride_i;
        end else if (step_i) begin
            walk_d.addr = walk_q.addr + walk_q.stride;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) walk_q <= '0;
        else         walk_q <= walk_d;
    end

    assign addr_o = walk_q.addr;

    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> (addr_o == AW'($past(addr_o) + $past(walk_q.stride)))); // R3

endmodule

// File: rtl/dmx_row_sequencer.sv
module dmx_row_sequencer
    import dmx_pkg::*;
#(
    parameter int unsigned LEN_W     = 32,
    parameter int unsigned REPS_W    = 16,
    parameter int unsigned FLAG_W    = 3,
    parameter bit          ENABLE_2D = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              accept_i,
    input  logic [REPS_W-1:0] reps_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              row_ready_i,
    output logic              row_valid_o,
    output logic              row_fire_o,
    output logic              idle_o,
    output logic [REPS_W-1:0] total_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [FLAG_W-1:0] flags_o
);

    typedef struct packed {
        gen_state_e        state;
        logic [REPS_W-1:0] rows_left;
        logic [LEN_W-1:0]  len;
        logic [FLAG_W-1:0] flags;
    } seq_t;

    seq_t seq_d, seq_q;

    localparam logic [REPS_W-1:0] ONE_ROW = REPS_W'(1);

    // Row count of the offered job
    generate
        if (ENABLE_2D) begin : g_two_d
            assign total_o = (reps_i == '0) ? ONE_ROW : reps_i;
        end else begin : g_flat
            logic unused_reps;
            assign unused_reps = ^reps_i;
            assign total_o     = ONE_ROW;
        end
    endgenerate

    assign row_valid_o = (seq_q.state == GEN_EMIT);
    assign row_fire_o  = row_valid_o && row_ready_i;
    assign idle_o      = (seq_q.state == GEN_IDLE);
    assign len_o       = seq_q.len;
    assign flags_o     = seq_q.flags;

    always_comb begin
        seq_d = seq_q;
        if (accept_i) begin
            seq_d.state     = GEN_EMIT;
            seq_d.rows_left = total_o;
            seq_d.len       = len_i;
            seq_d.flags     = flags_i;
        end else if (row_fire_o) begin
            seq_d.rows_left = seq_q.rows_left - ONE_ROW;
            if (seq_q.rows_left == ONE_ROW) begin
                seq_d.state = GEN_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{state: GEN_IDLE, default: '0};
        else         seq_q <= seq_d;
    end

    AST_ROWS_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row_valid_o |-> (seq_q.rows_left != '0)); // R3

    AST_FIELDS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_fire_o && seq_q.rows_left > ONE_ROW) |=>
            (row_valid_o && $stable(len_o) && $stable(flags_o))); // R5

    AST_NO_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |-> idle_o); // R7

endmodule

// File: rtl/dmx_done_tracker.sv
module dmx_done_tracker #(
    parameter int unsigned REPS_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              arm_i,
    input  logic [REPS_W-1:0] total_i,
    input  logic              row_done_i,
    output logic              busy_o,
    output logic              job_done_o
);

    typedef struct packed {
        logic              armed;
        logic              done;
        logic [REPS_W-1:0] total;
        logic [REPS_W-1:0] count;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [REPS_W-1:0] count_inc;

    assign count_inc = trk_q.count + REPS_W'(1);

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = 1'b0;
        if (arm_i) begin
            trk_d.armed = 1'b1;
            trk_d.total = total_i;
            trk_d.count = '0;
        end else if (trk_q.armed && row_done_i) begin
            trk_d.count = count_inc;
            if (count_inc == trk_q.total) begin
                trk_d.armed = 1'b0;
                trk_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trk_q <= '0;
        else         trk_q <= trk_d;
    end

    assign busy_o     = trk_q.armed;
    assign job_done_o = trk_q.done;

    AST_CNT_BELOW_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trk_q.armed |-> (trk_q.count < trk_q.total)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        job_done_o |=> !job_done_o); // R8

    AST_DONE_FROM_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(job_done_o) |-> $past(row_done_i)); // R8

endmodule

// File: rtl/dmx_row_expander.sv
module dmx_row_expander
    import dmx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 32,
    parameter int unsigned REPS_W    = 16,
    parameter int unsigned FLAG_W    = 3,
    parameter bit          ENABLE_2D = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              job_valid_i,
    output logic              job_ready_o,
    input  logic [ADDR_W-1:0] job_src_i,
    input  logic [ADDR_W-1:0] job_dst_i,
    input  logic [LEN_W-1:0]  job_len_i,
    input  logic [ADDR_W-1:0] job_src_stride_i,
    input  logic [ADDR_W-1:0] job_dst_stride_i,
    input  logic [REPS_W-1:0] job_reps_i,
    input  logic [FLAG_W-1:0] job_flags_i,
    output logic              row_valid_o,
    input  logic              row_ready_i,
    output logic [ADDR_W-1:0] row_src_o,
    output logic [ADDR_W-1:0] row_dst_o,
    output logic [LEN_W-1:0]  row_len_o,
    output logic [FLAG_W-1:0] row_flags_o,
    input  logic              row_done_i,
    output logic              job_done_o
);

    logic              seq_idle;
    logic              trk_busy;
    logic              accept;
    logic              row_fire;
    logic [REPS_W-1:0] job_total;

    logic [ADDR_W-1:0] ch_base   [NUM_ADDR_CH];
    logic [ADDR_W-1:0] ch_stride [NUM_ADDR_CH];
    logic [ADDR_W-1:0] ch_addr   [NUM_ADDR_CH];

    assign job_ready_o = seq_idle && !trk_busy;
    assign accept      = job_valid_i && job_ready_o;

    assign ch_base[0]   = job_src_i;
    assign ch_base[1]   = job_dst_i;
    assign ch_stride[0] = job_src_stride_i;
    assign ch_stride[1] = job_dst_stride_i;

    generate
        for (genvar c = 0; c < NUM_ADDR_CH; c++) begin : g_walk
            dmx_addr_walker #(
                .AW (ADDR_W)
            ) u_walk (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .load_i   (accept),
                .base_i   (ch_base[c]),
                .stride_i (ch_stride[c]),
                .step_i   (row_fire),
                .addr_o   (ch_addr[c])
            );
        end
    endgenerate

    assign row_src_o = ch_addr[0];
    assign row_dst_o = ch_addr[1];

    dmx_row_sequencer #(
        .LEN_W     (LEN_W),
        .REPS_W    (REPS_W),
        .FLAG_W    (FLAG_W),
        .ENABLE_2D (ENABLE_2D)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .accept_i    (accept),
        .reps_i      (job_reps_i),
        .len_i       (job_len_i),
        .flags_i     (job_flags_i),
        .row_ready_i (row_ready_i),
        .row_valid_o (row_valid_o),
        .row_fire_o  (row_fire),
        .idle_o      (seq_idle),
        .total_o     (job_total),
        .len_o       (row_len_o),
        .flags_o     (row_flags_o)
    );

    dmx_done_tracker #(
        .REPS_W (REPS_W)
    ) u_trk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .arm_i      (accept),
        .total_i    (job_total),
        .row_done_i (row_done_i),
        .busy_o     (trk_busy),
        .job_done_o (job_done_o)
    );

    AST_ROW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_valid_o && !row_ready_i) |=>
            (row_valid_o && $stable(row_src_o) && $stable(row_dst_o)
             && $stable(row_len_o) && $stable(row_flags_o))); // R6

    AST_CLOSED_WHILE_EMITTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row_valid_o |-> !job_ready_o); // R7

    AST_FIRST_ROW_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> row_valid_o); // R2

endmodule

// File: tb/tb_dmx_row_expander.sv
module tb_dmx_row_expander;

    localparam int AW = 8;
    localparam int LW = 6;
    localparam int RW = 3;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          sel = 1'b0;  // 0: two-dimensional build, 1: flat build
    logic          jv = 1'b0;
    logic [AW-1:0] j_src = '0, j_dst = '0, j_ss = '0, j_ds = '0;
    logic [LW-1:0] j_len = '0;
    logic [RW-1:0] j_reps = '0;
    logic [FW-1:0] j_flags = '0;
    logic          rr = 1'b0, rd = 1'b0;

    logic          jr0, rv0, jd0, jr1, rv1, jd1;
    logic [AW-1:0] rs0, rdst0, rs1, rdst1;
    logic [LW-1:0] rl0, rl1;
    logic [FW-1:0] rf0, rf1;

    dmx_row_expander #(.ADDR_W(AW), .LEN_W(LW), .REPS_W(RW), .FLAG_W(FW), .ENABLE_2D(1'b1)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .job_valid_i(jv && !sel), .job_ready_o(jr0),
        .job_src_i(j_src), .job_dst_i(j_dst), .job_len_i(j_len),
        .job_src_stride_i(j_ss), .job_dst_stride_i(j_ds),
        .job_reps_i(j_reps), .job_flags_i(j_flags),
        .row_valid_o(rv0), .row_ready_i(rr && !sel),
        .row_src_o(rs0), .row_dst_o(rdst0), .row_len_o(rl0), .row_flags_o(rf0),
        .row_done_i(rd && !sel), .job_done_o(jd0)
    );

    dmx_row_expander #(.ADDR_W(AW), .LEN_W(LW), .REPS_W(RW), .FLAG_W(FW), .ENABLE_2D(1'b0)) u_flat (
        .clk_i(clk), .rst_ni(rst_n),
        .job_valid_i(jv && sel), .job_ready_o(jr1),
        .job_src_i(j_src), .job_dst_i(j_dst), .job_len_i(j_len),
        .job_src_stride_i(j_ss), .job_dst_stride_i(j_ds),
        .job_reps_i(j_reps), .job_flags_i(j_flags),
        .row_valid_o(rv1), .row_ready_i(rr && sel),
        .row_src_o(rs1), .row_dst_o(rdst1), .row_len_o(rl1), .row_flags_o(rf1),
        .row_done_i(rd && sel), .job_done_o(jd1)
    );

    wire          m_jr   = sel ? jr1 : jr0;
    wire          m_rv   = sel ? rv1 : rv0;
    wire          m_jd   = sel ? jd1 : jd0;
    wire [AW-1:0] m_src  = sel ? rs1 : rs0;
    wire [AW-1:0] m_dst  = sel ? rdst1 : rdst0;
    wire [LW-1:0] m_len  = sel ? rl1 : rl0;
    wire [FW-1:0] m_flag = sel ? rf1 : rf0;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] lf = 8'h5A;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    task automatic run_job(input int s, input int d, input int ss, input int ds,
                           input int l, input int r, input int f, input bit junk);
        int  total;
        int  k = 0, pend = 0, comp = 0, guard = 0;
        bit  exp_done = 1'b0, fin = 1'b0, fire;
        bit  prev_stall = 1'b0;
        int  ps = 0, pd = 0;
        string tag;
        total = (r == 0 || sel) ? 1 : r;
        tag   = sel ? "R9" : ((r == 0) ? "R4" : "R3");
        @(negedge clk);
        chk(m_jr == 1'b1, "R7", "ready before job", int'(m_jr), 1);
        chk(m_rv == 1'b0, "R7", "no row before job", int'(m_rv), 0);
        chk(m_jd == 1'b0, "R8", "no done before job", int'(m_jd), 0);
        j_src = AW'(s); j_dst = AW'(d); j_ss = AW'(ss); j_ds = AW'(ds);
        j_len = LW'(l); j_reps = RW'(r); j_flags = FW'(f); jv = 1'b1;
        @(negedge clk);
        if (junk) begin
            // R7: offers made while busy must be ignored
            j_src = ~j_src; j_dst = ~j_dst; j_ss = ~j_ss; j_ds = ~j_ds;
            j_len = ~j_len; j_reps = ~j_reps; j_flags = ~j_flags; jv = 1'b1;
        end else begin
            jv = 1'b0;
        end
        while (!fin) begin
            chk(m_jd == exp_done, "R8", "done timing", int'(m_jd), int'(exp_done));
            if (exp_done) begin
                fin = 1'b1;
                jv  = 1'b0;
            end else begin
                chk(m_jr == 1'b0, "R7", "ready while busy", int'(m_jr), 0);
            end
            exp_done = 1'b0;
            if (prev_stall) begin
                chk(m_rv == 1'b1 && int'(m_src) == ps && int'(m_dst) == pd,
                    "R6", "held row src", int'(m_src), ps);
            end
            if (m_rv) begin
                if (k >= total) begin
                    chk(1'b0, tag, "extra row index", k, total);
                end else begin
                    int es, ed;
                    es = (s + k * ss) % 256;
                    ed = (d + k * ds) % 256;
                    chk(int'(m_src) == es, ((s + k * ss) > 255) ? "R10" : tag,
                        "row src", int'(m_src), es);
                    chk(int'(m_dst) == ed, ((d + k * ds) > 255) ? "R10" : tag,
                        "row dst", int'(m_dst), ed);
                    chk(int'(m_len) == l, (k == 0) ? "R2" : "R5", "row len", int'(m_len), l);
                    chk(int'(m_flag) == f, (k == 0) ? "R2" : "R5", "row flags", int'(m_flag), f);
                end
            end else if (!fin) begin
                chk(k >= total, tag, "row missing", k, total);
            end
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            rr = fin ? 1'b0 : (lf[0] | lf[2]);
            fire = m_rv && rr && (k < total);
            prev_stall = m_rv && !rr && !fin;
            ps = int'(m_src); pd = int'(m_dst);
            if (!fin && pend > 0 && lf[1]) begin
                rd = 1'b1; pend--; comp++;
                exp_done = (comp == total);
            end else begin
                rd = 1'b0;
            end
            if (fire) begin k++; pend++; end
            guard++;
            if (guard > 300) begin
                chk(1'b0, tag, "job never finished", comp, total);
                fin = 1'b1;
            end
            if (!fin) @(negedge clk);
        end
        rr = 1'b0; rd = 1'b0; jv = 1'b0;
        chk(k == total, tag, "rows emitted", k, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(jr0 == 1'b1, "R1", "ready in reset", int'(jr0), 1);
        chk(rv0 == 1'b0, "R1", "row valid in reset", int'(rv0), 0);
        chk(jd0 == 1'b0, "R1", "done in reset", int'(jd0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(jr0 == 1'b1 && rv0 == 1'b0 && jd0 == 1'b0, "R1", "after reset release",
            int'({jr0, rv0, jd0}), 4);

        // R8: stray completions while idle are ignored
        for (int i = 0; i < 3; i++) begin
            rd = 1'b1;
            @(negedge clk);
            chk(jd0 == 1'b0, "R8", "stray completion raised done", int'(jd0), 0);
        end
        rd = 1'b0;
        run_job(8'h10, 8'h20, 4, 8, 5, 2, 3, 1'b0);

        // R3 R4 R10 R5: sweep repetition counts and strides
        for (int r = 0; r < 8; r++) begin
            for (int si = 0; si < 4; si++) begin
                for (int di = 0; di < 2; di++) begin
                    int ss, ds;
                    ss = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 37 : 255;
                    ds = (di == 0) ? 3 : 128;
                    run_job(8'hF0 - r * 7, 8'h40 + si * 16, ss, ds,
                            (r * 5 + si) % 64, r, (r + di) % 8, (r + si) % 2 == 1);
                end
            end
        end

        // R9: flat build emits one row whatever the repetition count
        sel = 1'b1;
        @(negedge clk);
        chk(jr1 == 1'b1 && rv1 == 1'b0, "R9", "flat build idle", int'({jr1, rv1}), 2);
        for (int r = 0; r < 8; r++) begin
            run_job(8'h33 + r, 8'hC0 - r, 9, 17, r + 1, r, r, r[0]);
        end

        @(negedge clk);
        summary();
        $finish;
    end

endmodule